// File: doc/BRIEF.md
# UART Receive Character Queue with Automatic RTS

This block sits between a UART receive shift register and the host. Each character that the shift register completes is written in together with three per-character error tags. The host reads characters from a read-only holding view. Data and tags are kept side by side in every entry, so the tags shown in the line-status field always belong to the character that the host sees next. A data-ready flag reports that at least one character is waiting.

The queue has two modes. In queued mode it holds up to `DEPTH` characters and raises a receive interrupt once the fill reaches a programmable trigger count. In single-register mode it holds one character. Dropping the queued-mode enable empties the block.

When automatic flow control is armed, the block drives an active-low request-to-send output. The output goes high once the fill climbs more than `HYST` entries above the trigger, which pauses the remote transmitter. It returns low once the fill drops more than `HYST` below the trigger. Between the two thresholds it holds its state.

Top module: `uart_rx_fifo_rts`

## Requirements
- R1: In queued mode the block stores up to DEPTH (default 128) entries of 8 data bits plus 3 tag bits and delivers them in arrival order. A write while full is discarded and sets `overrun`, which stays high until a flush or reset.
- R2: `head_tags` shows the tags of the oldest stored character, and shows 0 when the queue is empty.
- R3: A read of a non-empty queue removes the head. After that clock edge, `head_data` and `head_tags` show the next character.
- R4: With `fifo_en` low, capacity is one character. A second write before a read is discarded and sets `overrun`.
- R5: In queued mode, `rx_irq` is high while fill >= `trig_lvl`, where a trigger of 0 acts as 1. In single-register mode, `rx_irq` is high while a character is held.
- R6: With automatic flow control active, `rts_n` goes high on the clock edge after the fill exceeds trigger + HYST (default HYST 8).
- R7: With automatic flow control active, `rts_n` goes low on the clock edge after the fill drops below trigger − HYST, or below 1 when the trigger is HYST or less. Between the thresholds `rts_n` keeps its value.
- R8: Automatic flow control is active only while `efr_auto`, `mcr_flow_en` and `fifo_en` are all high. Otherwise `rts_n` is driven low on the next edge.
- R9: A read of an empty queue changes nothing. `head_data` then shows the last character read out, or 0 after a flush or reset.
- R10: A falling `fifo_en` or a reset empties the block. It clears `head_tags`, `head_data`, `rx_irq` and `overrun`, and drives `rts_n` low.
- R11: `data_ready` is high exactly while at least one character is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the shift register |
| wr_data | input | 8 | Received byte |
| wr_tags | input | 3 | Error tags of the received byte |
| rd_en | input | 1 | Host read strobe of the holding view |
| fifo_en | input | 1 | Queued-mode enable; a falling value flushes |
| trig_lvl | input | CNT_W (8) | Receive trigger count |
| efr_auto | input | 1 | Enhanced-feature enable for automatic RTS |
| mcr_flow_en | input | 1 | Modem-control enable for automatic RTS |
| head_data | output | 8 | Oldest stored byte |
| head_tags | output | 3 | Tags of the oldest byte (line-status bits 4:2) |
| data_ready | output | 1 | At least one character stored |
| rx_irq | output | 1 | Receive trigger interrupt |
| rts_n | output | 1 | Active-low request-to-send |
| overrun | output | 1 | A write was discarded |

## Verification
Writes, reads and flushes are registered once. So `head_data`, `head_tags`, `data_ready`, `rx_irq` and `overrun` are due on the first edge after the strobe. `rts_n` is computed from the registered fill and settles one edge later. The bench drives on the falling edge and samples on the next falling edge. Before each flow-control check it inserts one idle cycle. A scoreboard queue supplies the expected head and tags after every read.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
   localparam int RXQ_DATA_W = 8;
   localparam int RXQ_TAG_W  = 3;

   typedef struct packed {
      logic [RXQ_TAG_W-1:0]  tags;
      logic [RXQ_DATA_W-1:0] data;
   } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
   import uart_rxq_pkg::*;
#(
   parameter int DEPTH = 128,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             fifo_en,
   input  logic             wr_en,
   input  rxq_entry_t       wr_entry,
   input  logic             rd_en,
   output rxq_entry_t       head_entry,
   output logic [CNT_W-1:0] count,
   output logic             overrun
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   rxq_entry_t mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
   logic [RXQ_DATA_W-1:0] last_q;
   logic [CNT_W-1:0] cap;
   logic push, pop;

   if (DEPTH < 2) begin : g_bad_depth
      $error("rxq_store: DEPTH must be at least 2");
   end

   assign cap  = fifo_en ? FULL_CNT : CNT_W'(1);
   assign push = wr_en && (count < cap) && !flush;
   assign pop  = rd_en && (count != '0) && !flush;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wr_ptr_nx = wr_ptr + 1'b1;
      assign rd_ptr_nx = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_ptr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_ptr_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wr_entry;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count   <= '0;
         overrun <= 1'b0;
         last_q  <= '0;
      end else if (flush) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count   <= '0;
         overrun <= 1'b0;
         last_q  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr_nx;
         if (pop) begin
            rd_ptr <= rd_ptr_nx;
            last_q <= mem[rd_ptr].data;
         end
         if (wr_en && !push) overrun <= 1'b1;
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   always_comb begin
      if (count != '0) begin
         head_entry = mem[rd_ptr];
      end else begin
         head_entry.tags = '0;
         head_entry.data = last_q;
      end
   end

   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
   assert_full_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && count >= cap && !rd_en && !flush) |=> ($stable(count) && overrun));
   assert_single_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && !flush) |-> count <= CNT_W'(1));
   assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && count == '0 && !wr_en) |=> count == '0);
   assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0 && !overrun));
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
   parameter int CNT_W = 8
) (
   input  logic             fifo_en,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] eff_trig,
   output logic             irq
);
   always_comb begin
      if (fifo_en) irq = (count >= eff_trig);
      else         irq = (count != '0);
   end
endmodule

// File: rtl/rxq_flow.sv
module rxq_flow #(
   parameter int CNT_W = 8,
   parameter int HYST  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             auto_en,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] eff_trig,
   output logic             rts_n
);
   localparam int W = CNT_W + 1;
   logic [W-1:0] hi_thr, lo_thr, cnt_w;

   if (HYST < 1) begin : g_bad_hyst
      $error("rxq_flow: HYST must be at least 1");
   end

   assign cnt_w  = W'(count);
   assign hi_thr = W'(eff_trig) + W'(HYST);
   assign lo_thr = (W'(eff_trig) > W'(HYST)) ? W'(eff_trig) - W'(HYST) : W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rts_n <= 1'b0;
      else if (flush || !auto_en) rts_n <= 1'b0;
      else if (cnt_w > hi_thr)   rts_n <= 1'b1;
      else if (cnt_w < lo_thr)   rts_n <= 1'b0;
   end

   assert_manual_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |=> !rts_n);
   assert_hold_band_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && !flush && cnt_w >= lo_thr && cnt_w <= hi_thr) |=> $stable(rts_n));
   assert_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && !flush && cnt_w > hi_thr) |=> rts_n);
endmodule

// File: rtl/uart_rx_fifo_rts.sv
module uart_rx_fifo_rts
   import uart_rxq_pkg::*;
#(
   parameter int DEPTH = 128,
   parameter int HYST  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [RXQ_DATA_W-1:0] wr_data,
   input  logic [RXQ_TAG_W-1:0]  wr_tags,
   input  logic                  rd_en,
   input  logic                  fifo_en,
   input  logic [CNT_W-1:0]      trig_lvl,
   input  logic                  efr_auto,
   input  logic                  mcr_flow_en,
   output logic [RXQ_DATA_W-1:0] head_data,
   output logic [RXQ_TAG_W-1:0]  head_tags,
   output logic                  data_ready,
   output logic                  rx_irq,
   output logic                  rts_n,
   output logic                  overrun
);
   rxq_entry_t wr_entry, head_entry;
   logic [CNT_W-1:0] count, eff_trig;
   logic fifo_q, flush, auto_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fifo_q <= 1'b0;
      else        fifo_q <= fifo_en;
   end

   assign flush    = fifo_q && !fifo_en;
   assign auto_en  = efr_auto && mcr_flow_en && fifo_en;
   assign eff_trig = (trig_lvl == '0) ? CNT_W'(1) : trig_lvl;
   assign wr_entry.data = wr_data;
   assign wr_entry.tags = wr_tags;

   rxq_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush), .fifo_en(fifo_en),
      .wr_en(wr_en), .wr_entry(wr_entry), .rd_en(rd_en),
      .head_entry(head_entry), .count(count), .overrun(overrun));

   rxq_irq #(.CNT_W(CNT_W)) u_irq (
      .fifo_en(fifo_en), .count(count), .eff_trig(eff_trig), .irq(rx_irq));

   rxq_flow #(.CNT_W(CNT_W), .HYST(HYST)) u_flow (
      .clk(clk), .rst_n(rst_n), .flush(flush), .auto_en(auto_en),
      .count(count), .eff_trig(eff_trig), .rts_n(rts_n));

   assign head_data  = head_entry.data;
   assign head_tags  = head_entry.tags;
   assign data_ready = (count != '0);

   assert_irq_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> data_ready);
   assert_empty_tags_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !data_ready |-> head_tags == '0);
   assert_ready_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush) |=> data_ready);
endmodule

// File: tb/uart_rx_fifo_rts_tb.sv
`timescale 1ns/1ps
module uart_rx_fifo_rts_tb;
   localparam int DEPTH = 128;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 0, rd_en = 0, fifo_en = 0, efr_auto = 0, mcr_flow_en = 0;
   logic [7:0] wr_data = '0;
   logic [2:0] wr_tags = '0;
   logic [CNT_W-1:0] trig_lvl = CNT_W'(16);
   logic [7:0] head_data;
   logic [2:0] head_tags;
   logic data_ready, rx_irq, rts_n, overrun;

   always #2.5 clk = ~clk;

   uart_rx_fifo_rts #(.DEPTH(DEPTH), .HYST(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_tags(wr_tags), .rd_en(rd_en), .fifo_en(fifo_en),
      .trig_lvl(trig_lvl), .efr_auto(efr_auto), .mcr_flow_en(mcr_flow_en),
      .head_data(head_data), .head_tags(head_tags), .data_ready(data_ready),
      .rx_irq(rx_irq), .rts_n(rts_n), .overrun(overrun));

   int vecs = 0, errs = 0;
   logic [10:0] exp_q[$];
   logic [7:0] m_last = '0;
   bit m_ov = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // driver: pushes expected items into the scoreboard
   task automatic put(input logic [7:0] d, input logic [2:0] t);
      int cap;
      cap = fifo_en ? DEPTH : 1;
      wr_en = 1; wr_data = d; wr_tags = t;
      @(negedge clk);
      wr_en = 0;
      if (exp_q.size() < cap) exp_q.push_back({t, d});
      else m_ov = 1;
   endtask

   // monitor: compares the head against the scoreboard front
   task automatic look(input string req);
      logic [7:0] ed;
      logic [2:0] et;
      ed = exp_q.size() != 0 ? exp_q[0][7:0] : m_last;
      et = exp_q.size() != 0 ? exp_q[0][10:8] : 3'd0;
      chk(head_data == ed, req, "head_data", head_data, ed);
      chk(head_tags == et, "R2", "head_tags", head_tags, et);
      chk(data_ready == (exp_q.size() != 0), "R11", "data_ready",
          data_ready, exp_q.size() != 0);
   endtask

   task automatic take(input string req);
      look(req);
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
      if (exp_q.size() != 0) m_last = exp_q.pop_front()[7:0];
      look("R3");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      idle(2);
      // R10 reset state
      chk(!data_ready && !rx_irq && !rts_n && !overrun && head_tags == 0 && head_data == 0,
          "R10", "reset outputs", {data_ready, rx_irq, rts_n, overrun}, 0);
      rst_n = 1;
      idle(1);

      // queued mode, trigger 16, automatic RTS armed
      fifo_en = 1; efr_auto = 1; mcr_flow_en = 1;
      idle(1);
      for (int i = 0; i < 15; i++) put(8'h40 + 8'(i), 3'(i));
      chk(!rx_irq, "R5", "irq at 15", rx_irq, 0);
      put(8'h4F, 3'd5);
      chk(rx_irq, "R5", "irq at 16", rx_irq, 1);
      for (int i = 16; i < 24; i++) put(8'h40 + 8'(i), 3'(i));
      idle(1);
      chk(!rts_n, "R7", "rts at 24 holds low", rts_n, 0);
      put(8'h99, 3'd7);
      chk(!rts_n, "R6", "rts before lag", rts_n, 0);
      idle(1);
      chk(rts_n, "R6", "rts high above 24", rts_n, 1);
      for (int i = 0; i < 17; i++) take("R1");
      idle(1);
      chk(rts_n, "R7", "rts holds at 8", rts_n, 1);
      take("R1");
      idle(1);
      chk(!rts_n, "R7", "rts low below 8", rts_n, 0);
      chk(!rx_irq, "R5", "irq below trigger", rx_irq, 0);
      while (exp_q.size() != 0) take("R1");
      // R9 empty read
      take("R9");
      put(8'hA5, 3'd3);
      look("R9");
      take("R3");

      // fill to capacity and overflow
      for (int i = 0; i < DEPTH + 2; i++) put(8'(i * 7), 3'(i + 1));
      chk(overrun == m_ov, "R1", "overrun on full", overrun, m_ov);
      for (int i = 0; i < 3; i++) take("R1");

      // R10 flush by dropping queued mode
      fifo_en = 0;
      idle(1);
      idle(1);
      exp_q.delete(); m_last = 0; m_ov = 0;
      chk(!data_ready && !rx_irq && !rts_n && !overrun && head_tags == 0 && head_data == 0,
          "R10", "flush outputs", {data_ready, rx_irq, rts_n, overrun}, 0);

      // R4 single-register mode
      put(8'h3C, 3'd6);
      chk(rx_irq, "R5", "irq single mode", rx_irq, 1);
      put(8'hC3, 3'd1);
      chk(overrun && m_ov, "R4", "second write dropped", overrun, 1);
      take("R4");
      take("R9");

      // R8 automatic RTS disarmed
      fifo_en = 1; efr_auto = 0;
      idle(1);
      for (int i = 0; i < 30; i++) put(8'(i), 3'd0);
      idle(2);
      chk(!rts_n, "R8", "rts low without auto", rts_n, 0);
      efr_auto = 1;
      idle(2);
      chk(rts_n, "R8", "rts high once armed", rts_n, 1);
      mcr_flow_en = 0;
      idle(1);
      chk(!rts_n, "R8", "rts low when modem bit off", rts_n, 0);
      take("R3");

      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule